// File: doc/BRIEF.md
# Atomic Bit Test-and-Complement Unit

This unit performs one indivisible test-and-complement on a single bit of a 24-bit word. A command carries a bit index, a target code and an address. For a word held in one of two memory spaces, the unit issues a read, captures the chosen bit into a carry flag, and writes the word back with only that bit inverted. It keeps a bus lock raised from the read request until the write is acknowledged, so no other master can reach the word between the two accesses. Processors sharing a memory can therefore use the operation as a semaphore: the carry shows what the bit held before this unit changed it.

A register target goes through a local register-file port and needs no bus cycle. The unit reads the register combinationally and writes it back on the edge that accepts the command. An index outside the word aborts the command. The abort leaves the target and the carry unchanged and is reported with an illegal pulse. The unit accepts one command at a time, and a one-cycle done pulse marks the end of each command.

Top module: `bit_flip_atomic`

## Requirements
- R1: After reset, cmd_ready is 1 and bus_req, bus_lock, done, illegal, rf_we and carry are all 0.
- R2: For a legal index (0 to 23), carry takes the value the selected bit held before the operation.
- R3: The stored word equals the old word with only bit cmd_bit inverted. For example, 0x000000 with index 7 becomes 0x000080 and carry becomes 0.
- R4: A memory command makes exactly one read and then exactly one write to the same address. cmd_tgt 0 selects X space and 1 selects Y space, and bus_space shows the selection as 0 or 1. The other space is not touched.
- R5: bus_lock is high in every cycle in which bus_req is high. It is high from the read request through the write acknowledge and low in the cycle after the write acknowledge.
- R6: While bus_req is high and bus_ack is low, bus_we, bus_addr and bus_wdata stay stable, for any number of wait states.
- R7: cmd_ready is low from acceptance until completion. A command presented while cmd_ready is low has no effect.
- R8: done is a single-cycle pulse. It comes in the cycle after the write acknowledge for memory targets, and in the cycle after acceptance for register targets and illegal commands.
- R9: cmd_tgt 2 or 3 selects a register. No bus request is made, rf_we pulses in the accepting cycle with rf_addr equal to the low address bits, and rf_wdata is rf_rdata with the selected bit inverted.
- R10: An index of 24 or more makes illegal pulse together with done. No bus access and no register write take place, and carry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to accept |
| cmd_bit | input | 5 | Bit index |
| cmd_tgt | input | 2 | 0 X memory, 1 Y memory, 2/3 register |
| cmd_addr | input | ADDR_W | Memory address or register number |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Index out of range, valid with done |
| carry | output | 1 | Carry flag (old bit value) |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 1 | 0 X space, 1 Y space |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| bus_lock | output | 1 | Bus held for this unit |
| rf_addr | output | RF_AW | Register-file address |
| rf_rdata | input | DATA_W | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | DATA_W | Register-file write data |

## Verification
The bench uses both ends of the index range, with bit 0 and bit 23. A shift or decode error at either end would invert a neighbouring bit or produce the wrong carry. Memory commands run with zero and several wait states. A design that released the lock early, counted an acknowledge twice, or let the write data drift while waiting would show up as a wrong stored word or extra bus traffic. Further checks cover an out-of-range index after the carry has been set to 1, which a careless design would clear or pass on to the target, and a command presented while the unit is busy, which a design that does not block it would execute against the register file.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } btc_state_t;

  localparam logic [1:0] TGT_XMEM = 2'd0;
  localparam logic [1:0] TGT_YMEM = 2'd1;
endpackage

// File: rtl/btc_rst_sync.sv
module btc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/btc_mask.sv
module btc_mask #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask,
  output logic              legal
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign legal = ({1'b0, idx} < (IDX_W+1)'(DATA_W));
endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_is_reg,
  input  logic cmd_legal,
  input  logic bus_ack,
  output logic cmd_ready,
  output logic load_cmd,
  output logic read_cap,
  output logic rf_fire,
  output logic bus_req,
  output logic bus_we,
  output logic bus_lock,
  output logic done,
  output logic illegal
);
  btc_state_t state_q, state_d;
  logic done_d, ill_d;
  logic accept;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid & cmd_ready;
  assign load_cmd  = accept & cmd_legal & ~cmd_is_reg;
  assign rf_fire   = accept & cmd_legal & cmd_is_reg;
  assign bus_req   = (state_q == ST_RD) | (state_q == ST_WR);
  assign bus_we    = (state_q == ST_WR);
  assign bus_lock  = bus_req;
  assign read_cap  = (state_q == ST_RD) & bus_ack;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!cmd_legal) begin
            done_d = 1'b1;
            ill_d  = 1'b1;
          end else if (cmd_is_reg) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (bus_ack) state_d = ST_WR;
      end
      ST_WR: begin
        if (bus_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      illegal <= ill_d;
    end
  end
endmodule

// File: rtl/btc_dpath.sv
module btc_dpath #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cmd,
  input  logic [DATA_W-1:0] cmd_mask,
  input  logic              cmd_space,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              read_cap,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              rf_fire,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_space,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              carry
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              space_q, space_d;
  logic              carry_q, carry_d;

  always_comb begin
    mask_d  = mask_q;
    addr_d  = addr_q;
    space_d = space_q;
    hold_d  = hold_q;
    carry_d = carry_q;
    if (load_cmd) begin
      mask_d  = cmd_mask;
      addr_d  = cmd_addr;
      space_d = cmd_space;
    end
    if (read_cap) begin
      hold_d  = bus_rdata;
      carry_d = |(bus_rdata & mask_q);
    end else if (rf_fire) begin
      carry_d = |(rf_rdata & cmd_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      addr_q  <= '0;
      space_q <= 1'b0;
      hold_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      addr_q  <= addr_d;
      space_q <= space_d;
      hold_q  <= hold_d;
      carry_q <= carry_d;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_space = space_q;
  assign bus_wdata = hold_q ^ mask_q;
  assign rf_wdata  = rf_rdata ^ cmd_mask;
  assign carry     = carry_q;
endmodule

// File: rtl/bit_flip_atomic.sv
module bit_flip_atomic #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int RF_AW  = 3,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_bit,
  input  logic [1:0]        cmd_tgt,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              done,
  output logic              illegal,
  output logic              carry,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_space,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              bus_lock,
  output logic [RF_AW-1:0]  rf_addr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] cmd_mask;
  logic              cmd_legal;
  logic              load_cmd, read_cap, rf_fire;

  btc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  btc_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .idx   (cmd_bit),
    .mask  (cmd_mask),
    .legal (cmd_legal)
  );

  btc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_is_reg (cmd_tgt[1]),
    .cmd_legal  (cmd_legal),
    .bus_ack    (bus_ack),
    .cmd_ready  (cmd_ready),
    .load_cmd   (load_cmd),
    .read_cap   (read_cap),
    .rf_fire    (rf_fire),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_lock   (bus_lock),
    .done       (done),
    .illegal    (illegal)
  );

  btc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_cmd  (load_cmd),
    .cmd_mask  (cmd_mask),
    .cmd_space (cmd_tgt[0]),
    .cmd_addr  (cmd_addr),
    .read_cap  (read_cap),
    .bus_rdata (bus_rdata),
    .rf_fire   (rf_fire),
    .rf_rdata  (rf_rdata),
    .bus_addr  (bus_addr),
    .bus_space (bus_space),
    .bus_wdata (bus_wdata),
    .rf_wdata  (rf_wdata),
    .carry     (carry)
  );

  assign rf_addr = cmd_addr[RF_AW-1:0];
  assign rf_we   = rf_fire;
endmodule

// File: rtl/btc_chk.sv
module btc_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              done,
  input logic              illegal,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic              bus_lock,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rf_we
);
  assert_lock_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_lock);

  assert_unlock_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_ack) |=> !bus_lock);

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

  assert_hold_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                               && $stable(bus_wdata)));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cmd_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reg_no_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !bus_req);

  assert_illegal_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
endmodule

bind bit_flip_atomic btc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_bit_flip_atomic.sv
`timescale 1ns/1ps
module sim_bit_flip_atomic;
  localparam int DW = 24;
  localparam int AW = 16;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [4:0]    cmd_bit;
  logic [1:0]    cmd_tgt;
  logic [AW-1:0] cmd_addr;
  logic          done, illegal, carry;
  logic          bus_req, bus_we, bus_space, bus_lock;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_ack;
  logic [RW-1:0] rf_addr;
  logic [DW-1:0] rf_rdata;
  logic          rf_we;
  logic [DW-1:0] rf_wdata;

  int total = 0;
  int bad = 0;
  int ws = 0;
  int wcnt = 0;
  int nrd = 0;
  int nwr = 0;
  int lock_bad = 0;
  int rf_writes = 0;
  logic got_ill;

  logic [DW-1:0] xmem [16];
  logic [DW-1:0] ymem [16];
  logic [DW-1:0] rf   [8];

  always #2.5 clk = ~clk;

  bit_flip_atomic u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bit(cmd_bit), .cmd_tgt(cmd_tgt), .cmd_addr(cmd_addr),
    .done(done), .illegal(illegal), .carry(carry),
    .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_lock(bus_lock),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  assign rf_rdata = rf[rf_addr];

  always @(posedge clk) begin
    if (rf_we) begin
      rf[rf_addr] <= rf_wdata;
      rf_writes   <= rf_writes + 1;
    end
  end

  // bus slave with programmable wait states
  always @(negedge clk) begin
    if (bus_req && !bus_lock) lock_bad++;
    if (bus_ack) begin
      bus_ack = 1'b0;
      wcnt    = 0;
    end else if (bus_req) begin
      if (wcnt >= ws) begin
        bus_ack = 1'b1;
        wcnt    = 0;
        if (bus_we) begin
          if (bus_space) ymem[bus_addr[3:0]] = bus_wdata;
          else           xmem[bus_addr[3:0]] = bus_wdata;
          nwr++;
        end else begin
          bus_rdata = bus_space ? ymem[bus_addr[3:0]] : xmem[bus_addr[3:0]];
          nrd++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done seen"}, 32'(done), 32'd1);
    got_ill = illegal;
    chk(!bus_lock, "R5 lock low at done", 32'(bus_lock), 32'd0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic run_op(input logic [4:0] b, input logic [1:0] t,
                        input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_bit   = b;
    cmd_tgt   = t;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(tag);
  endtask

  task automatic t_reset();
    chk(cmd_ready, "R1 ready", 32'(cmd_ready), 32'd1);
    chk(!bus_req && !bus_lock, "R1 bus idle", {30'd0, bus_req, bus_lock}, 32'd0);
    chk(!done && !illegal && !rf_we, "R1 pulses low",
        {29'd0, done, illegal, rf_we}, 32'd0);
    chk(!carry, "R1 carry", 32'(carry), 32'd0);
  endtask

  task automatic t_vector();
    int r0 = nrd;
    int w0 = nwr;
    ws = 0;
    xmem[2] = 24'h000000;
    ymem[2] = 24'h555555;
    run_op(5'd7, 2'd0, 16'd2, "R3 vector");
    chk(xmem[2] == 24'h000080, "R3 vector word", 32'(xmem[2]), 32'h80);
    chk(!carry, "R2 vector carry", 32'(carry), 32'd0);
    chk(nrd == r0 + 1 && nwr == w0 + 1, "R4 one read one write",
        32'((nrd - r0) * 16 + (nwr - w0)), 32'h11);
    chk(ymem[2] == 24'h555555, "R4 other space untouched", 32'(ymem[2]), 32'h555555);
  endtask

  task automatic t_top_bit_y();
    ws = 3;
    ymem[3] = 24'hFFFFFF;
    xmem[3] = 24'h000000;
    run_op(5'd23, 2'd1, 16'd3, "R6 wait states");
    chk(ymem[3] == 24'h7FFFFF, "R3 bit23 Y word", 32'(ymem[3]), 32'h7FFFFF);
    chk(carry, "R2 bit23 carry", 32'(carry), 32'd1);
    chk(xmem[3] == 24'h000000, "R4 Y op leaves X", 32'(xmem[3]), 32'd0);
  endtask

  task automatic t_low_bit_x();
    ws = 1;
    xmem[5] = 24'hA5A5A4;
    run_op(5'd0, 2'd0, 16'd5, "R3 bit0");
    chk(xmem[5] == 24'hA5A5A5, "R3 bit0 word", 32'(xmem[5]), 32'hA5A5A5);
    chk(!carry, "R2 bit0 carry clear", 32'(carry), 32'd0);
  endtask

  task automatic t_register();
    int r0 = nrd;
    rf[5] = 24'h123456;
    run_op(5'd4, 2'd2, 16'd5, "R9 reg");
    chk(rf[5] == 24'h123446, "R9 reg word", 32'(rf[5]), 32'h123446);
    chk(carry, "R9 reg carry set", 32'(carry), 32'd1);
    run_op(5'd0, 2'd3, 16'd5, "R9 reg2");
    chk(rf[5] == 24'h123447, "R9 reg word2", 32'(rf[5]), 32'h123447);
    chk(!carry, "R9 reg carry clear", 32'(carry), 32'd0);
    chk(nrd == r0, "R9 no bus traffic", 32'(nrd - r0), 32'd0);
  endtask

  task automatic t_illegal();
    int r0;
    int f0;
    ws = 0;
    ymem[6] = 24'h800000;
    run_op(5'd23, 2'd1, 16'd6, "R10 setup");
    chk(carry, "R10 setup carry", 32'(carry), 32'd1);
    r0 = nrd;
    xmem[1] = 24'h000001;
    run_op(5'd24, 2'd0, 16'd1, "R10 mem");
    chk(got_ill, "R10 illegal flag", 32'(got_ill), 32'd1);
    chk(xmem[1] == 24'h000001, "R10 mem unchanged", 32'(xmem[1]), 32'h1);
    chk(carry, "R10 carry kept", 32'(carry), 32'd1);
    chk(nrd == r0, "R10 no bus", 32'(nrd - r0), 32'd0);
    f0 = rf_writes;
    rf[2] = 24'h00FF00;
    run_op(5'd31, 2'd2, 16'd2, "R10 reg");
    chk(got_ill, "R10 reg illegal flag", 32'(got_ill), 32'd1);
    chk(rf_writes == f0 && rf[2] == 24'h00FF00, "R10 reg unchanged",
        32'(rf[2]), 32'h00FF00);
    run_op(5'd8, 2'd2, 16'd2, "R10 legal after");
    chk(!got_ill, "R10 legal no flag", 32'(got_ill), 32'd0);
  endtask

  task automatic t_busy();
    ws = 4;
    xmem[4] = 24'h000000;
    rf[6]   = 24'h000000;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_bit   = 5'd12;
    cmd_tgt   = 2'd0;
    cmd_addr  = 16'd4;
    @(negedge clk);
    chk(!cmd_ready, "R7 ready low when busy", 32'(cmd_ready), 32'd0);
    cmd_bit  = 5'd0;
    cmd_tgt  = 2'd2;
    cmd_addr = 16'd6;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done("R7 busy");
    chk(rf[6] == 24'h000000, "R7 ignored command", 32'(rf[6]), 32'd0);
    chk(xmem[4] == 24'h001000, "R7 active op word", 32'(xmem[4]), 32'h1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      xmem[i] = '0;
      ymem[i] = '0;
    end
    for (int i = 0; i < 8; i++) rf[i] = '0;
    bus_ack   = 1'b0;
    bus_rdata = '0;
    cmd_valid = 1'b0;
    cmd_bit   = '0;
    cmd_tgt   = '0;
    cmd_addr  = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_vector();
    t_top_bit_y();
    t_low_bit_x();
    t_register();
    t_illegal();
    t_busy();
    chk(lock_bad == 0, "R5 request without lock", 32'(lock_bad), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule